// File: doc/BRIEF.md
# Banked Mode Switch and Exception Entry Unit

This unit keeps the mode-banked copies of two general registers (r29 and r30) and of the saved status word, one bank per processor mode. It also carries out the architectural state update when an exception is taken. The surrounding core presents its live status word and program counter. It then either asks for a plain mode change or raises one of four exception types. The unit swaps the banks, rewrites the status word and, for an exception, saves the return address and produces the vector address that the program counter must take next.

The live copies of r29, r30 and the saved status are visible at the outputs. Outside a mode change or an exception, the register file can write them through a small write port. Each request is accepted at one clock edge, and its full result appears right after that same edge.

Top module: `exc_bank_unit`

## Requirements
- R1: While reset is active and right after it, r29_o, r30_o, bsr_o, status_o and pc_o read zero, and done_o and err_o are low.
- R2: A mode-change request (sw_valid_i) whose target mode differs from the mode in cur_status_i[4:0] first stores the live r29, r30 and saved status into the bank of the current mode. It then loads all three from the bank of the target mode. status_o becomes cur_status_i with bits [4:0] replaced by the target mode.
- R3: When the target mode equals the current mode code, no bank is stored or loaded and the live registers keep their values, apart from the exception updates in R5 and R7.
- R4: Mode codes are user 0x10, interrupt 0x12, privileged 0x13, trap 0x17 and system 0x1F. Exception type 1 (fetch trap) and type 2 (data trap) enter trap mode, type 3 (interrupt) enters interrupt mode, and type 0 (software call) enters privileged mode. An exception takes priority over a mode-change request in the same cycle.
- R5: On exception entry the bank swap comes first. The live saved status of the new mode then receives the whole cur_status_i, and the saved status of the old mode stays in the old mode's bank.
- R6: On exception entry status_o becomes cur_status_i with bits [4:0] set to the new mode and the interrupt-disable bit 7 set. All other bits are copied unchanged.
- R7: On exception entry the live r30 of the new mode receives cur_pc_i, and pc_o receives the vector address, which is the base plus 4 times the exception type.
- R8: vec_hi_i low selects base 0x0000_0000, and vec_hi_i high selects base 0xFFFF_0000.
- R9: A request whose current or target mode code is not one of the five codes in R4 raises err_o for one cycle and leaves all outputs and banks unchanged.
- R10: done_o is high for exactly the one cycle after the edge that accepted an exception, and is low after mode changes, writes and rejected requests.
- R11: With no request pending, wr_en_i writes wr_data_i into live r29 (wr_sel_i=0), r30 (1) or saved status (2), and value 3 writes nothing. During a request cycle the write is ignored.
- R12: User mode and system mode share one bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid_i | input | 1 | Exception request |
| exc_type_i | input | 2 | Exception type: 0 software call, 1 fetch trap, 2 data trap, 3 interrupt |
| vec_hi_i | input | 1 | Vector base select |
| cur_status_i | input | 32 | Live status word, mode in bits [4:0] |
| cur_pc_i | input | 32 | Live program counter |
| sw_valid_i | input | 1 | Plain mode-change request |
| sw_mode_i | input | 5 | Target mode of a mode change |
| wr_en_i | input | 1 | Live banked register write enable |
| wr_sel_i | input | 2 | Write target: 0 r29, 1 r30, 2 saved status |
| wr_data_i | input | 32 | Write data |
| r29_o | output | 32 | Live r29 |
| r30_o | output | 32 | Live r30 |
| bsr_o | output | 32 | Live saved status |
| status_o | output | 32 | Updated status word |
| pc_o | output | 32 | Vector address after exception entry |
| done_o | output | 1 | Exception entry completed |
| err_o | output | 1 | Unknown mode code rejected |

## Verification
Every result of a request passes through exactly one register. A request driven for one cycle therefore shows its swapped banks, status word, vector and done or error pulse during the cycle after the accepting edge. The bench drives inputs at the falling edge, lets one rising edge pass, and reads all outputs at the next falling edge. It then drives an idle cycle and checks that done_o and err_o have dropped and that the live registers have held.

// File: rtl/exc_bank_pkg.sv
package exc_bank_pkg;

    localparam int XLEN      = 32;
    localparam int MODE_W    = 5;
    localparam int NUM_BANKS = 4;
    localparam int BANK_W    = $clog2(NUM_BANKS);
    localparam int ETYPE_W   = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_USER = 5'h10,
        MODE_INTR = 5'h12,
        MODE_PRIV = 5'h13,
        MODE_TRAP = 5'h17,
        MODE_SYS  = 5'h1F
    } mode_e;

    typedef enum logic [ETYPE_W-1:0] {
        EXC_SWI    = 2'd0,
        EXC_IFETCH = 2'd1,
        EXC_DATA   = 2'd2,
        EXC_IRQ    = 2'd3
    } exc_e;

    typedef struct packed {
        logic [XLEN-1:0] r29;
        logic [XLEN-1:0] r30;
        logic [XLEN-1:0] bsr;
    } bank_t;

    typedef struct packed {
        bank_t [NUM_BANKS-1:0] banks;
        bank_t                 live;
        logic [XLEN-1:0]       status;
        logic [XLEN-1:0]       pc;
        logic                  done;
        logic                  err;
    } unit_state_t;

endpackage

// File: rtl/exc_mode_decode.sv
module exc_mode_decode
    import exc_bank_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output logic [BANK_W-1:0] bank_o,
    output logic              valid_o
);
    always_comb begin
        valid_o = 1'b1;
        bank_o  = '0;
        case (mode_i)
            MODE_USER, MODE_SYS: bank_o = BANK_W'(0);
            MODE_PRIV:           bank_o = BANK_W'(1);
            MODE_TRAP:           bank_o = BANK_W'(2);
            MODE_INTR:           bank_o = BANK_W'(3);
            default: begin
                valid_o = 1'b0;
                bank_o  = '0;
            end
        endcase
    end
endmodule

// File: rtl/exc_target.sv
module exc_target
    import exc_bank_pkg::*;
#(
    parameter logic [XLEN-1:0] VEC_LO     = 32'h0000_0000,
    parameter logic [XLEN-1:0] VEC_HI     = 32'hFFFF_0000,
    parameter int              VEC_STRIDE = 4
) (
    input  logic [ETYPE_W-1:0] type_i,
    input  logic               hi_sel_i,
    output logic [MODE_W-1:0]  mode_o,
    output logic [XLEN-1:0]    vec_o
);
    localparam logic [XLEN-1:0] STRIDE = XLEN'(VEC_STRIDE);

    always_comb begin
        case (exc_e'(type_i))
            EXC_IFETCH, EXC_DATA: mode_o = MODE_TRAP;
            EXC_IRQ:              mode_o = MODE_INTR;
            default:              mode_o = MODE_PRIV;
        endcase
        vec_o = (hi_sel_i ? VEC_HI : VEC_LO) + STRIDE * XLEN'(type_i);
    end
endmodule

// File: rtl/exc_bank_unit.sv
module exc_bank_unit
    import exc_bank_pkg::*;
#(
    parameter logic [XLEN-1:0] VEC_LO     = 32'h0000_0000,
    parameter logic [XLEN-1:0] VEC_HI     = 32'hFFFF_0000,
    parameter int              VEC_STRIDE = 4,
    parameter int              IDIS_BIT   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exc_valid_i,
    input  logic [1:0]         exc_type_i,
    input  logic               vec_hi_i,
    input  logic [31:0]        cur_status_i,
    input  logic [31:0]        cur_pc_i,
    input  logic               sw_valid_i,
    input  logic [4:0]         sw_mode_i,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_sel_i,
    input  logic [31:0]        wr_data_i,
    output logic [31:0]        r29_o,
    output logic [31:0]        r30_o,
    output logic [31:0]        bsr_o,
    output logic [31:0]        status_o,
    output logic [31:0]        pc_o,
    output logic               done_o,
    output logic               err_o
);
    unit_state_t st_d, st_q;

    logic [MODE_W-1:0] cur_mode;
    logic [MODE_W-1:0] exc_mode;
    logic [MODE_W-1:0] tgt_mode;
    logic [XLEN-1:0]   vec_addr;
    logic [BANK_W-1:0] cur_bank, tgt_bank;
    logic              cur_ok, tgt_ok;
    logic              req;

    assign cur_mode = cur_status_i[MODE_W-1:0];
    assign tgt_mode = exc_valid_i ? exc_mode : sw_mode_i;
    assign req      = exc_valid_i | sw_valid_i;

    exc_target #(
        .VEC_LO    (VEC_LO),
        .VEC_HI    (VEC_HI),
        .VEC_STRIDE(VEC_STRIDE)
    ) u_target (
        .type_i  (exc_type_i),
        .hi_sel_i(vec_hi_i),
        .mode_o  (exc_mode),
        .vec_o   (vec_addr)
    );

    exc_mode_decode u_cur_dec (
        .mode_i (cur_mode),
        .bank_o (cur_bank),
        .valid_o(cur_ok)
    );

    exc_mode_decode u_tgt_dec (
        .mode_i (tgt_mode),
        .bank_o (tgt_bank),
        .valid_o(tgt_ok)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;
        if (req) begin
            if (!cur_ok || !tgt_ok) begin
                st_d.err = 1'b1;
            end else begin
                if (cur_mode != tgt_mode) begin
                    st_d.banks[cur_bank] = st_q.live;
                    st_d.live            = st_d.banks[tgt_bank];
                end
                st_d.status               = cur_status_i;
                st_d.status[MODE_W-1:0]   = tgt_mode;
                if (exc_valid_i) begin
                    st_d.live.bsr          = cur_status_i;
                    st_d.live.r30          = cur_pc_i;
                    st_d.status[IDIS_BIT]  = 1'b1;
                    st_d.pc                = vec_addr;
                    st_d.done              = 1'b1;
                end
            end
        end else if (wr_en_i) begin
            case (wr_sel_i)
                2'd0:    st_d.live.r29 = wr_data_i;
                2'd1:    st_d.live.r30 = wr_data_i;
                2'd2:    st_d.live.bsr = wr_data_i;
                default: st_d.live     = st_q.live;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign r29_o    = st_q.live.r29;
    assign r30_o    = st_q.live.r30;
    assign bsr_o    = st_q.live.bsr;
    assign status_o = st_q.status;
    assign pc_o     = st_q.pc;
    assign done_o   = st_q.done;
    assign err_o    = st_q.err;

endmodule

// File: rtl/exc_bank_chk.sv
module exc_bank_chk #(
    parameter logic [31:0] VEC_LO     = 32'h0000_0000,
    parameter logic [31:0] VEC_HI     = 32'hFFFF_0000,
    parameter int          VEC_STRIDE = 4,
    parameter int          IDIS_BIT   = 7
) (
    input logic        clk,
    input logic        rst_n,
    input logic        exc_valid_i,
    input logic [1:0]  exc_type_i,
    input logic        vec_hi_i,
    input logic [31:0] cur_status_i,
    input logic [31:0] cur_pc_i,
    input logic [31:0] r29_o,
    input logic [31:0] r30_o,
    input logic [31:0] bsr_o,
    input logic [31:0] status_o,
    input logic [31:0] pc_o,
    input logic        done_o,
    input logic        err_o
);
    AST_DONE_NEEDS_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(exc_valid_i)); // R10
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o)); // R9
    AST_IDIS_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (status_o[IDIS_BIT] && status_o[31:8] == $past(cur_status_i[31:8]))); // R6
    AST_RET_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> r30_o == $past(cur_pc_i)); // R7
    AST_SAVED_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> bsr_o == $past(cur_status_i)); // R5
    AST_VECTOR_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> pc_o == (($past(vec_hi_i) ? VEC_HI : VEC_LO)
                            + 32'(VEC_STRIDE) * 32'($past(exc_type_i)))); // R8
    AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ($stable(r29_o) && $stable(r30_o) && $stable(bsr_o)
                   && $stable(status_o) && $stable(pc_o))); // R9
endmodule

bind exc_bank_unit exc_bank_chk #(
    .VEC_LO    (VEC_LO),
    .VEC_HI    (VEC_HI),
    .VEC_STRIDE(VEC_STRIDE),
    .IDIS_BIT  (IDIS_BIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .exc_valid_i (exc_valid_i),
    .exc_type_i  (exc_type_i),
    .vec_hi_i    (vec_hi_i),
    .cur_status_i(cur_status_i),
    .cur_pc_i    (cur_pc_i),
    .r29_o       (r29_o),
    .r30_o       (r30_o),
    .bsr_o       (bsr_o),
    .status_o    (status_o),
    .pc_o        (pc_o),
    .done_o      (done_o),
    .err_o       (err_o)
);

// File: tb/tb_exc_bank_unit.sv
module tb_exc_bank_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        exc_valid_i;
    logic [1:0]  exc_type_i;
    logic        vec_hi_i;
    logic [31:0] cur_status_i;
    logic [31:0] cur_pc_i;
    logic        sw_valid_i;
    logic [4:0]  sw_mode_i;
    logic        wr_en_i;
    logic [1:0]  wr_sel_i;
    logic [31:0] wr_data_i;
    logic [31:0] r29_o, r30_o, bsr_o, status_o, pc_o;
    logic        done_o, err_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_bank_unit dut (
        .clk(clk), .rst_n(rst_n),
        .exc_valid_i(exc_valid_i), .exc_type_i(exc_type_i), .vec_hi_i(vec_hi_i),
        .cur_status_i(cur_status_i), .cur_pc_i(cur_pc_i),
        .sw_valid_i(sw_valid_i), .sw_mode_i(sw_mode_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .r29_o(r29_o), .r30_o(r30_o), .bsr_o(bsr_o), .status_o(status_o),
        .pc_o(pc_o), .done_o(done_o), .err_o(err_o)
    );

    localparam logic [31:0] A1 = 32'h1111_0029, A2 = 32'h1111_0030, A3 = 32'h1111_00B5;
    localparam logic [31:0] A1N = 32'h1111_AAAA;
    localparam logic [31:0] B1 = 32'h2222_0029, B2 = 32'h2222_0030, B3 = 32'h2222_00B5;
    localparam logic [31:0] C1 = 32'h3333_0029;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_regs(input string tag, input logic [31:0] e29,
                            input logic [31:0] e30, input logic [31:0] ebsr);
        chk({tag, " r29"}, r29_o, e29);
        chk({tag, " r30"}, r30_o, e30);
        chk({tag, " bsr"}, bsr_o, ebsr);
    endtask

    function automatic logic [31:0] entry_status(input logic [31:0] s, input logic [4:0] m);
        return {s[31:8], 1'b1, s[6:5], m};
    endfunction

    task automatic idle_inputs();
        exc_valid_i = 0; exc_type_i = 0; vec_hi_i = 0; cur_status_i = 0; cur_pc_i = 0;
        sw_valid_i = 0; sw_mode_i = 0; wr_en_i = 0; wr_sel_i = 0; wr_data_i = 0;
    endtask

    // drive for one cycle starting at a falling edge, return at the next falling edge
    task automatic step();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        wr_en_i = 1; wr_sel_i = sel; wr_data_i = data;
        step();
    endtask

    task automatic sw(input logic [4:0] from_m, input logic [4:0] to_m, input logic [31:0] hi);
        sw_valid_i = 1; sw_mode_i = to_m; cur_status_i = {hi[31:5], from_m};
        step();
    endtask

    task automatic exc(input logic [1:0] t, input logic vh, input logic [31:0] st,
                       input logic [31:0] pc);
        exc_valid_i = 1; exc_type_i = t; vec_hi_i = vh; cur_status_i = st; cur_pc_i = pc;
        step();
    endtask

    task automatic t_reset();
        chk_regs("R1 reset", 0, 0, 0);
        chk("R1 status", status_o, 0);
        chk("R1 pc", pc_o, 0);
        chk("R1 done", {31'b0, done_o}, 0);
        chk("R1 err", {31'b0, err_o}, 0);
    endtask

    task automatic t_write();
        wr(2'd0, A1); wr(2'd1, A2); wr(2'd2, A3);
        wr(2'd3, 32'hFFFF_FFFF);
        chk_regs("R11 write", A1, A2, A3);
    endtask

    task automatic t_switch();
        sw(5'h10, 5'h13, 32'h0);
        chk_regs("R2 user->priv", 0, 0, 0);
        chk("R2 status mode", status_o, 32'h0000_0013);
        chk("R10 no done on switch", {31'b0, done_o}, 0);
        wr(2'd0, B1); wr(2'd1, B2); wr(2'd2, B3);
        sw(5'h13, 5'h10, 32'h0);
        chk_regs("R2 priv->user", A1, A2, A3);
    endtask

    task automatic t_shared_and_same();
        sw(5'h10, 5'h1F, 32'h0);
        chk_regs("R12 user->sys", A1, A2, A3);
        wr(2'd0, A1N);
        sw(5'h1F, 5'h10, 32'h0);
        chk_regs("R12 sys->user", A1N, A2, A3);
        sw(5'h10, 5'h10, 32'h0);
        chk_regs("R3 same mode", A1N, A2, A3);
        sw(5'h10, 5'h13, 32'h0);
        chk_regs("R2 back to priv", B1, B2, B3);
    endtask

    task automatic t_irq();
        exc(2'd3, 1'b0, 32'h5A5A_0C13, 32'h0000_4000);
        chk_regs("R5 R7 irq entry", 0, 32'h0000_4000, 32'h5A5A_0C13);
        chk("R6 irq status", status_o, entry_status(32'h5A5A_0C13, 5'h12));
        chk("R8 low vector", pc_o, 32'h0000_000C);
        chk("R10 done", {31'b0, done_o}, 1);
        step();
        chk("R10 done drops", {31'b0, done_o}, 0);
        sw(5'h12, 5'h13, 32'h0);
        chk_regs("R5 old bsr kept", B1, B2, B3);
    endtask

    task automatic t_traps();
        exc(2'd1, 1'b1, 32'h0000_0013, 32'h8000_0100);
        chk_regs("R4 fetch trap", 0, 32'h8000_0100, 32'h0000_0013);
        chk("R4 trap status", status_o, entry_status(32'h0000_0013, 5'h17));
        chk("R8 high vector", pc_o, 32'hFFFF_0004);
        wr(2'd0, C1);
        exc(2'd2, 1'b1, 32'h0000_0117, 32'h8000_0200);
        chk_regs("R3 R4 data trap same mode", C1, 32'h8000_0200, 32'h0000_0117);
        chk("R6 data trap status", status_o, entry_status(32'h0000_0117, 5'h17));
        chk("R8 data trap vector", pc_o, 32'hFFFF_0008);
    endtask

    task automatic t_swi_with_write();
        wr_en_i = 1; wr_sel_i = 0; wr_data_i = 32'hDEAD_BEEF;
        exc(2'd0, 1'b0, 32'h0000_0017, 32'h8000_0300);
        chk_regs("R11 R4 swi, write ignored", B1, 32'h8000_0300, 32'h0000_0017);
        chk("R6 swi status", status_o, entry_status(32'h0000_0017, 5'h13));
        chk("R7 swi vector", pc_o, 32'h0000_0000);
    endtask

    task automatic t_unknown();
        sw(5'h13, 5'h05, 32'h0);
        chk("R9 err on bad target", {31'b0, err_o}, 1);
        chk_regs("R9 regs held", B1, 32'h8000_0300, 32'h0000_0017);
        chk("R9 status held", status_o, entry_status(32'h0000_0017, 5'h13));
        chk("R10 no done on err", {31'b0, done_o}, 0);
        exc(2'd3, 1'b1, 32'h0000_0000, 32'h1234_5678);
        chk("R9 err on bad current", {31'b0, err_o}, 1);
        chk_regs("R9 regs held exc", B1, 32'h8000_0300, 32'h0000_0017);
        chk("R9 pc held", pc_o, 32'h0000_0000);
        step();
        chk("R9 err drops", {31'b0, err_o}, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write();
        t_switch();
        t_shared_and_same();
        t_irq();
        t_traps();
        t_swi_with_write();
        t_unknown();
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule